// File: doc/BRIEF.md
# Programmable Countdown Event Timer

This block is a register-mapped event timer for a tick-driven timebase. Software writes a 56-bit reload value in two parts: the low 32 bits in a word of their own, and the upper 24 bits packed into the control word beside the run, repeat and load flags. A control write with the load flag set copies the whole 56-bit value into the down-counter. After that, every cycle in which the `tick` input is high and the timer is running moves the count down by one.

When the count expires, a pending flag is set. In repeat mode the counter restarts from the stored reload value and keeps running. In single-shot mode the run flag clears and the counter stops. The level interrupt output is the pending flag gated by an interrupt-enable bit. Software clears the pending flag by writing a one to a clear register. A control write of zero stops the timer. The `tick` input is meant to come from a prescaled timebase of about 2 MHz. Software should not program a delay shorter than 2 ticks.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and `irq` is low. `bus_rdata` reads 0 whenever `bus_re` is low.
- R2: Offset 0x00 holds the low reload word and reads it back. Offset 0x04 is the control word: bits [23:0] hold reload bits [55:32], bit 24 is run, bit 28 is repeat and bit 30 is load. Bit 30 and every bit not named here read as 0.
- R3: A control write with bit 30 set loads the counter with {wdata[23:0], low reload word}. A control write with bit 30 clear updates the stored fields but leaves the counter as it was.
- R4: While run is set, each cycle with `tick` high lowers the count by one. The pending flag sets on the tick that takes a loaded value N (N ≥ 1) through its Nth decrement. While run is clear, ticks have no effect.
- R5: In single-shot mode, expiry clears the run bit (control bit 24 reads 0), and later ticks raise no further event.
- R6: In repeat mode, expiry reloads the counter from the stored 56-bit value and the run bit stays set, so an event occurs every N ticks.
- R7: Bit 0 of offset 0x2C is the interrupt enable and reads back. `irq` is high exactly when both the pending flag and that enable are set.
- R8: Writing 1 to bit 0 of offset 0x34 clears the pending flag, and writing 0 there has no effect. Reading 0x34 returns the pending flag in bit 0.
- R9: A control write of 0 stops the counter, so no event follows however many ticks arrive.
- R10: A tick in the same cycle as a loading control write is ignored, so a loaded value N still needs N further ticks.
- R11: An expiry in the same cycle as a clear write leaves the pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 32 | Read data, 0 when not reading |
| tick | input | 1 | Timebase enable, one decrement per high cycle |
| irq | output | 1 | Level interrupt |

## Verification
Assertions check these rules on every cycle:
- A running counter decrements by exactly one per tick.
- A loading write places the composed 56-bit value in the counter.
- Repeat expiry restores the stored reload value.
- Single-shot expiry drops the run bit.
- Expiry always sets the pending flag, and a clear with no coincident expiry empties it.
- The load bit never reads back as 1.

Only the bench scenarios can show the following:
- Event spacing as seen from the ports.
- That a write without the load bit leaves an in-flight count alone.
- That the stop write and the disabled state silence the timer over long runs of ticks.
- The coincidence cases where a tick meets a load, or an expiry meets a clear.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int CNT_W    = 56;
    localparam int HI_W     = CNT_W - DATA_W;

    localparam logic [ADDR_W-1:0] OFF_RELOAD_LO = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CTRL      = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_IRQ_EN    = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_IRQ_CLR   = 8'h34;

    localparam int BIT_RUN    = 24;
    localparam int BIT_REPEAT = 28;
    localparam int BIT_LOAD   = 30;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RELOAD_LO,
        SEL_CTRL,
        SEL_IRQ_EN,
        SEL_IRQ_CLR
    } reg_sel_e;
endpackage

// File: rtl/evt_bus_decode.sv
module evt_bus_decode
    import evt_timer_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output reg_sel_e          sel,
    output logic              wr_lo,
    output logic              wr_ctrl,
    output logic              wr_ie,
    output logic              wr_clr
);
    always_comb begin
        case (addr)
            OFF_RELOAD_LO: sel = SEL_RELOAD_LO;
            OFF_CTRL:      sel = SEL_CTRL;
            OFF_IRQ_EN:    sel = SEL_IRQ_EN;
            OFF_IRQ_CLR:   sel = SEL_IRQ_CLR;
            default:       sel = SEL_NONE;
        endcase
        wr_lo   = we && (sel == SEL_RELOAD_LO);
        wr_ctrl = we && (sel == SEL_CTRL);
        wr_ie   = we && (sel == SEL_IRQ_EN);
        wr_clr  = we && (sel == SEL_IRQ_CLR);
    end
endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter #(
    parameter int CNT_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    input  logic             rpt,
    input  logic [CNT_W-1:0] reload,
    output logic             expire
);
    logic [CNT_W-1:0] count_d, count_q;
    logic             step;

    always_comb begin
        step    = run && tick && !load;
        expire  = step && (count_q <= CNT_W'(1));
        count_d = count_q;
        if (load)
            count_d = load_val;
        else if (expire)
            count_d = rpt ? reload : '0;
        else if (step)
            count_d = count_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // R4: one decrement per accepted tick
    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - CNT_W'(1)));

    // R3: a load places the composed value
    a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(load_val)));

    // R6: repeat expiry restores the reload
    a_r6_repeat_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && rpt) |=> (count_q == $past(reload)));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] reload_lo;
        logic [HI_W-1:0]   reload_hi;
        logic              run;
        logic              rpt;
        logic              ie;
        logic              pend;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     wr_lo, wr_ctrl, wr_ie, wr_clr;
    logic     load_cmd, expire;

    evt_bus_decode u_dec (
        .addr    (bus_addr),
        .we      (bus_we),
        .sel     (sel),
        .wr_lo   (wr_lo),
        .wr_ctrl (wr_ctrl),
        .wr_ie   (wr_ie),
        .wr_clr  (wr_clr)
    );

    assign load_cmd = wr_ctrl && bus_wdata[BIT_LOAD];

    evt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cmd),
        .load_val ({bus_wdata[HI_W-1:0], regs_q.reload_lo}),
        .run      (regs_q.run),
        .tick     (tick),
        .rpt      (regs_q.rpt),
        .reload   ({regs_q.reload_hi, regs_q.reload_lo}),
        .expire   (expire)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_lo)
            regs_d.reload_lo = bus_wdata;
        if (wr_ctrl) begin
            regs_d.reload_hi = bus_wdata[HI_W-1:0];
            regs_d.run       = bus_wdata[BIT_RUN];
            regs_d.rpt       = bus_wdata[BIT_REPEAT];
        end else if (expire && !regs_q.rpt) begin
            regs_d.run = 1'b0;
        end
        if (wr_ie)
            regs_d.ie = bus_wdata[0];
        if (expire)
            regs_d.pend = 1'b1;
        else if (wr_clr && bus_wdata[0])
            regs_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (sel)
                SEL_RELOAD_LO: bus_rdata = regs_q.reload_lo;
                SEL_CTRL: begin
                    bus_rdata[HI_W-1:0]  = regs_q.reload_hi;
                    bus_rdata[BIT_RUN]    = regs_q.run;
                    bus_rdata[BIT_REPEAT] = regs_q.rpt;
                end
                SEL_IRQ_EN:  bus_rdata[0] = regs_q.ie;
                SEL_IRQ_CLR: bus_rdata[0] = regs_q.pend;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign irq = regs_q.pend && regs_q.ie;

    // R5: single-shot expiry drops the run bit
    a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !regs_q.rpt && !wr_ctrl) |=> !regs_q.run);

    // R4: expiry always raises the pending flag
    a_r4_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> regs_q.pend);

    // R8: a clear with no expiry empties the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && bus_wdata[0] && !expire) |=> !regs_q.pend);

    // R2: the load bit never reads back set
    a_r2_load_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[BIT_LOAD]);

    // R1: quiet read bus
    a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0));
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [31:0] C_RUN  = 32'h0100_0000;
    localparam logic [31:0] C_RPT  = 32'h1000_0000;
    localparam logic [31:0] C_LOAD = 32'h4000_0000;

    always #10 clk = ~clk;

    evt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .tick(tick), .irq(irq)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic expect_pend(input logic exp, input string req);
        logic [31:0] v;
        rd(8'h34, v);
        check(v[0] == exp, req, v, {31'b0, exp});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check(v == 0, "R1 lo", v, 0);
        rd(8'h04, v); check(v == 0, "R1 ctrl", v, 0);
        rd(8'h2C, v); check(v == 0, "R1 ie", v, 0);
        rd(8'h34, v); check(v == 0, "R1 pend", v, 0);
        check(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);
        @(negedge clk); #1 check(bus_rdata == 0, "R1 idle rdata", bus_rdata, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(8'h00, 32'hA5A5_0003);
        rd(8'h00, v); check(v == 32'hA5A5_0003, "R2 lo", v, 32'hA5A5_0003);
        wr(8'h04, C_LOAD | C_RPT | C_RUN | 32'hAE12_3456);
        rd(8'h04, v); check(v == 32'h1112_3456, "R2 ctrl", v, 32'h1112_3456);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(8'h2C, 32'h1);
        rd(8'h2C, v); check(v == 1, "R7 ie readback", v, 1);
        wr(8'h00, 32'd5);
        wr(8'h04, C_LOAD | C_RUN);
        ticks(4); expect_pend(1'b0, "R4 before N");
        ticks(1); expect_pend(1'b1, "R4 at N");
        check(irq == 1'b1, "R7 irq high", {31'b0, irq}, 1);
        rd(8'h04, v); check(v[24] == 1'b0, "R5 run cleared", v, 0);
        wr(8'h34, 32'h0); expect_pend(1'b1, "R8 zero write");
        wr(8'h34, 32'h1); expect_pend(1'b0, "R8 clear");
        check(irq == 1'b0, "R7 irq low", {31'b0, irq}, 0);
        ticks(10); expect_pend(1'b0, "R5 no second event");
    endtask

    task automatic t_halted();
        wr(8'h00, 32'd2);
        wr(8'h04, C_LOAD);
        ticks(5); expect_pend(1'b0, "R4 run clear ignores ticks");
    endtask

    task automatic t_repeat();
        logic [31:0] v;
        wr(8'h00, 32'd3);
        wr(8'h04, C_LOAD | C_RUN | C_RPT);
        ticks(3); expect_pend(1'b1, "R6 first event");
        rd(8'h04, v); check(v[24] == 1'b1, "R6 run kept", v, C_RUN);
        wr(8'h34, 32'h1);
        ticks(2); expect_pend(1'b0, "R6 mid period");
        ticks(1); expect_pend(1'b1, "R6 second event");
        wr(8'h34, 32'h1);
        ticks(2);
        wr(8'h04, 32'h0);
        ticks(6); expect_pend(1'b0, "R9 stopped");
    endtask

    task automatic t_irq_gate();
        wr(8'h2C, 32'h0);
        wr(8'h00, 32'd2);
        wr(8'h04, C_LOAD | C_RUN);
        ticks(2); expect_pend(1'b1, "R7 pend without ie");
        check(irq == 1'b0, "R7 gated", {31'b0, irq}, 0);
        wr(8'h2C, 32'h1);
        @(negedge clk); check(irq == 1'b1, "R7 ungated", {31'b0, irq}, 1);
        wr(8'h34, 32'h1);
    endtask

    task automatic t_noload();
        wr(8'h00, 32'd4);
        wr(8'h04, C_LOAD | C_RUN);
        ticks(2);
        wr(8'h00, 32'd100);
        wr(8'h04, C_RUN | 32'h0000_0077);
        ticks(1); expect_pend(1'b0, "R3 count kept");
        ticks(1); expect_pend(1'b1, "R3 no reload");
        wr(8'h34, 32'h1);
    endtask

    task automatic t_load_tick();
        wr(8'h00, 32'd3);
        wr_tick(8'h04, C_LOAD | C_RUN);
        ticks(2); expect_pend(1'b0, "R10 tick ignored");
        ticks(1); expect_pend(1'b1, "R10 full count");
        wr(8'h34, 32'h1);
    endtask

    task automatic t_set_wins();
        wr(8'h00, 32'd2);
        wr(8'h04, C_LOAD | C_RUN | C_RPT);
        ticks(1);
        wr_tick(8'h34, 32'h1);
        expect_pend(1'b1, "R11 expiry beats clear");
        wr(8'h04, 32'h0);
        wr(8'h34, 32'h1);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_oneshot();
        t_halted();
        t_repeat();
        t_irq_gate();
        t_noload();
        t_load_tick();
        t_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule